// File: doc/BRIEF.md
# Dual-Clock Alarm Status Register with Timed Clear

This block holds one read-only status byte that reports the alarm state of two monitored input clocks, A and B. Each clock has three flags. The frequency hard alarm and no-activity alarm flags register live condition inputs every cycle. The phase-lock alarm flag is sticky: a one-cycle event pulse sets it, and it stays set until it is cleared.

A configuration bit selects how the phase-lock flag clears. In manual mode, software writes a one to the flag's bit position. In timed mode, the flag clears by itself after a programmable number of seconds. That number is a 6-bit value times a 2-bit multiplier. Each clock has its own counter, driven by a one-second tick input. The counter starts when the alarm is raised and restarts on every new event.

Top module: `clk_alarm_status`

## Requirements
- R1: The status byte is laid out as follows. Bit 6 is the clock B frequency alarm, bit 5 the clock B no-activity alarm and bit 4 the clock B phase-lock alarm. Bit 2 is the clock A frequency alarm, bit 1 the clock A no-activity alarm and bit 0 the clock A phase-lock alarm. Bits 7 and 3 always read 0.
- R2: The frequency and no-activity bits show the value their condition input had in the previous cycle. Input index 0 is clock A and index 1 is clock B.
- R3: During and after a synchronous reset, the status byte reads 0x66 until a rising edge changes one of the registered inputs.
- R4: An event pulse sets the matching phase-lock bit in the next cycle. The bit then stays set with no further events.
- R5: When the mode input is 0, writing a 1 at bit 0 or bit 4 clears that phase-lock bit in the next cycle. Writing 0 there, or writing any other bit, changes nothing.
- R6: When the mode input is 1, a phase-lock bit clears on the N-th tick after it was raised, where N = timeout value × multiplier. Writes have no effect on the phase-lock bits in this mode.
- R7: A new event on a set phase-lock bit restarts that clock's tick count from zero.
- R8: If an event arrives in the same cycle as a write clear or a timed clear, the bit stays set.
- R9: When the mode is timed and N is 0, the phase-lock bit clears on the first tick after it was raised.
- R10: When the mode input is 0, ticks never clear a phase-lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status byte |
| wr_data | input | 8 | Write data; a 1 at bit 0 or 4 clears in manual mode |
| rd_data | output | 8 | Status byte |
| freq_alarm_in | input | 2 | Live frequency hard alarm conditions (bit 0 = A) |
| idle_alarm_in | input | 2 | Live no-activity alarm conditions (bit 0 = A) |
| lock_event | input | 2 | Phase-lock alarm event pulses (bit 0 = A) |
| auto_clear_mode | input | 1 | 0 = write-one-to-clear, 1 = timed clear |
| timeout_val | input | 6 | Timeout base in seconds |
| timeout_mult | input | 2 | Timeout multiplier |
| sec_tick | input | 1 | One-cycle pulse every second |

## Verification
The bench targets the collision between an event and a clear. A design that let the clear win would drop an alarm raised in the very cycle software acknowledged it. It checks that writes to non-lock bits and ticks in manual mode leave the byte unchanged; a careless write decoder would corrupt live flags or clear the wrong clock. The timed path is checked at N = 0, at a small N, and at the maximum of 189 ticks. This exposes an off-by-one compare, a counter that wraps, and a counter that is not restarted by a repeated event.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int NUM_CLK = 2;
    localparam int VAL_W   = 6;
    localparam int MULT_W  = 2;
    localparam int PROD_W  = VAL_W + MULT_W;
    localparam int GRP_W   = 4;

    // bit position of each clock's phase-lock flag inside the status byte
    localparam int LOCK_POS_A = 0;
    localparam int LOCK_POS_B = LOCK_POS_A + GRP_W;

    typedef struct packed {
        logic freq;
        logic idle;
        logic lock;
    } alm_grp_t;

    function automatic logic [7:0] pack_status(input alm_grp_t grp_a, input alm_grp_t grp_b);
        return {1'b0, grp_b, 1'b0, grp_a};
    endfunction

    function automatic logic [PROD_W-1:0] timeout_ticks(input logic [VAL_W-1:0] val,
                                                         input logic [MULT_W-1:0] mult);
        return PROD_W'(val) * PROD_W'(mult);
    endfunction

endpackage

// File: rtl/live_flag_reg.sv
module live_flag_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cond_in,
    output logic [N-1:0] flag_q
);
    always_ff @(posedge clk) begin
        if (rst) flag_q <= '1;
        else     flag_q <= cond_in;
    end
endmodule

// File: rtl/lock_alarm_chan.sv
module lock_alarm_chan
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              raise,
    input  logic              wr_clr,
    input  logic              auto_mode,
    input  logic              tick,
    input  logic [PROD_W-1:0] limit,
    output logic              alarm
);
    logic [PROD_W-1:0] cnt_q;
    logic [PROD_W:0]   cnt_inc;
    logic              expire;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = auto_mode && tick && (cnt_inc >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm <= 1'b0;
            cnt_q <= '0;
        end else if (raise) begin
            alarm <= 1'b1;
            cnt_q <= '0;
        end else if (alarm) begin
            if (!auto_mode) begin
                if (wr_clr) alarm <= 1'b0;
                cnt_q <= '0;
            end else if (expire) begin
                alarm <= 1'b0;
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_inc[PROD_W-1:0];
            end
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/clk_alarm_status.sv
module clk_alarm_status
    import alm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic [1:0]  freq_alarm_in,
    input  logic [1:0]  idle_alarm_in,
    input  logic [1:0]  lock_event,
    input  logic        auto_clear_mode,
    input  logic [5:0]  timeout_val,
    input  logic [1:0]  timeout_mult,
    input  logic        sec_tick
);
    logic [NUM_CLK-1:0] freq_q;
    logic [NUM_CLK-1:0] idle_q;
    logic [NUM_CLK-1:0] lock_q;
    logic [PROD_W-1:0]  limit;
    alm_grp_t           grp [NUM_CLK];

    assign limit = timeout_ticks(timeout_val, timeout_mult);

    live_flag_reg #(.N(NUM_CLK)) u_freq (
        .clk(clk), .rst(rst), .cond_in(freq_alarm_in), .flag_q(freq_q));

    live_flag_reg #(.N(NUM_CLK)) u_idle (
        .clk(clk), .rst(rst), .cond_in(idle_alarm_in), .flag_q(idle_q));

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_chan
        lock_alarm_chan u_lock (
            .clk      (clk),
            .rst      (rst),
            .raise    (lock_event[i]),
            .wr_clr   (wr_en && wr_data[LOCK_POS_A + i*GRP_W]),
            .auto_mode(auto_clear_mode),
            .tick     (sec_tick),
            .limit    (limit),
            .alarm    (lock_q[i])
        );
        assign grp[i] = '{freq: freq_q[i], idle: idle_q[i], lock: lock_q[i]};
    end

    assign rd_data = pack_status(grp[0], grp[1]);
endmodule

// File: rtl/clk_alarm_status_chk.sv
module clk_alarm_status_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic [1:0] freq_alarm_in,
    input logic [1:0] idle_alarm_in,
    input logic [1:0] lock_event,
    input logic       auto_clear_mode,
    input logic       sec_tick
);
    // R2: live flags lag their inputs by one cycle
    a_r2_freq_follow: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rd_data[2] == $past(freq_alarm_in[0]) && rd_data[6] == $past(freq_alarm_in[1])));
    a_r2_idle_follow: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rd_data[1] == $past(idle_alarm_in[0]) && rd_data[5] == $past(idle_alarm_in[1])));

    // R4 / R8: an event always leaves the bit set
    a_r4_event_sets_a: assert property (@(posedge clk) disable iff (rst)
        lock_event[0] |=> rd_data[0]);
    a_r4_event_sets_b: assert property (@(posedge clk) disable iff (rst)
        lock_event[1] |=> rd_data[4]);

    // R5: manual-mode write of 1 clears when no event collides
    a_r5_w1c_a: assert property (@(posedge clk) disable iff (rst)
        (!auto_clear_mode && wr_en && wr_data[0] && !lock_event[0]) |=> !rd_data[0]);

    // R6 / R10: a drop needs a cause matching the mode
    a_r6_drop_cause_a: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[0]) |-> $past((!auto_clear_mode && wr_en && wr_data[0]) ||
                                    (auto_clear_mode && sec_tick)));
    a_r6_drop_cause_b: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[4]) |-> $past((!auto_clear_mode && wr_en && wr_data[4]) ||
                                    (auto_clear_mode && sec_tick)));
endmodule

bind clk_alarm_status clk_alarm_status_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .freq_alarm_in(freq_alarm_in), .idle_alarm_in(idle_alarm_in),
    .lock_event(lock_event), .auto_clear_mode(auto_clear_mode), .sec_tick(sec_tick));

// File: tb/clk_alarm_status_test.sv
module clk_alarm_status_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] freq_alarm_in = '0;
    logic [1:0] idle_alarm_in = '0;
    logic [1:0] lock_event = '0;
    logic       auto_clear_mode = 1'b0;
    logic [5:0] timeout_val = 6'd2;
    logic [1:0] timeout_mult = 2'd1;
    logic       sec_tick = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    clk_alarm_status uut (.*);

    // {wr_en, wr_data[8], freq[2], idle[2], event[2], mode, tick, expect[8]}
    localparam int NV = 22;
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 8'h00},  // R2 all quiet
        {1'b0, 8'h00, 2'b01, 2'b10, 2'b00, 1'b0, 1'b0, 8'h24},  // R1 R2 mixed
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b01, 1'b0, 1'b0, 8'h01},  // R4 raise A
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b10, 1'b0, 1'b0, 8'h11},  // R4 raise B, A sticky
        {1'b1, 8'h01, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 8'h10},  // R5 clear A
        {1'b1, 8'hEE, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 8'h10},  // R5 other bits
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b0, 1'b1, 8'h10},  // R10 tick ignored
        {1'b1, 8'h10, 2'b00, 2'b00, 2'b10, 1'b0, 1'b0, 8'h10},  // R8 event wins
        {1'b1, 8'h10, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 8'h00},  // R5 clear B
        {1'b1, 8'h11, 2'b00, 2'b00, 2'b11, 1'b0, 1'b0, 8'h11},  // R8 both
        {1'b1, 8'h11, 2'b00, 2'b00, 2'b00, 1'b0, 1'b0, 8'h00},  // R5 both
        {1'b0, 8'h00, 2'b11, 2'b11, 2'b00, 1'b0, 1'b0, 8'h66},  // R1 R2 all live
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b01, 1'b1, 1'b0, 8'h01},  // R6 raise A timed
        {1'b1, 8'h01, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 8'h01},  // R6 write ignored
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h01},  // R6 tick 1 of 2
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b0, 8'h01},  // R6 no tick
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h00},  // R6 tick 2 clears
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0, 8'h10},  // R6 raise B
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h10},  // R7 tick 1
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b10, 1'b1, 1'b0, 8'h10},  // R7 restart
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h10},  // R7 tick 1 again
        {1'b0, 8'h00, 2'b00, 2'b00, 2'b00, 1'b1, 1'b1, 8'h00}   // R7 tick 2 clears
    };

    task automatic check(input string req, input logic [7:0] exp);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] wd, input logic [1:0] ev,
                       input logic tk);
        @(negedge clk);
        wr_en = we; wr_data = wd; lock_event = ev; sec_tick = tk;
        @(posedge clk);
        #2;
        wr_en = 1'b0; lock_event = '0; sec_tick = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: rd_data=%02h expected=done", rd_data);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R3 reset value", 8'h66);
        @(negedge clk); rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = VEC[v][24]; wr_data = VEC[v][23:16];
            freq_alarm_in = VEC[v][15:14]; idle_alarm_in = VEC[v][13:12];
            lock_event = VEC[v][11:10]; auto_clear_mode = VEC[v][9];
            sec_tick = VEC[v][8];
            @(posedge clk);
            #2;
            check($sformatf("R1-table vec %0d", v), VEC[v][7:0]);
        end
        wr_en = 1'b0; lock_event = '0; sec_tick = 1'b0;

        // R9: product zero via multiplier 0
        timeout_val = 6'd17; timeout_mult = 2'd0;
        cyc(1'b0, 8'h00, 2'b01, 1'b0);
        check("R9 raised", 8'h01);
        cyc(1'b0, 8'h00, 2'b00, 1'b1);
        check("R9 first tick clears", 8'h00);

        // R6: maximum product 63*3 = 189 ticks
        timeout_val = 6'd63; timeout_mult = 2'd3;
        cyc(1'b0, 8'h00, 2'b10, 1'b0);
        for (int t = 0; t < 188; t++) cyc(1'b0, 8'h00, 2'b00, 1'b1);
        check("R6 still set after 188 ticks", 8'h10);
        cyc(1'b0, 8'h00, 2'b00, 1'b1);
        check("R6 cleared at tick 189", 8'h00);

        // R8: event beats a timed clear
        timeout_val = 6'd1; timeout_mult = 2'd1;
        cyc(1'b0, 8'h00, 2'b01, 1'b0);
        cyc(1'b0, 8'h00, 2'b01, 1'b1);
        check("R8 event beats expiry", 8'h01);
        cyc(1'b0, 8'h00, 2'b00, 1'b1);
        check("R6 single tick clears", 8'h00);

        // R10: manual mode, many ticks do nothing
        auto_clear_mode = 1'b0;
        cyc(1'b0, 8'h00, 2'b11, 1'b0);
        for (int t = 0; t < 5; t++) cyc(1'b0, 8'h00, 2'b00, 1'b1);
        check("R10 ticks ignored", 8'h11);
        cyc(1'b1, 8'hEE, 2'b00, 1'b0);
        check("R5 zero at lock bits ignored", 8'h11);

        // R3: reset mid-alarm
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        check("R3 reset clears lock", 8'h66);
        @(negedge clk); rst = 1'b0;

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule